// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the combinational arithmetic and logic stage of a small accumulator-based processor. The decoder supplies a 3-bit operation code, the accumulator value, a second operand, the current carry flag and a unary select. The block returns the new result byte, five status flags and a write-back enable. It updates no state of its own. The surrounding core latches the result and the flags on its own clock.

The binary operations combine the accumulator with the operand. They are add, add with carry, subtract, subtract with borrow, AND, XOR, OR and compare. When the unary select asks for increment or decrement, the operation code and the accumulator are ignored. The operand is then stepped by one and returned with its own flag rules. The surrounding core chooses which register or memory byte is presented as the operand.

Top module: `alu8_core`

## Requirements
- R1: The operation code selects the binary function: 000 add, 001 add with carry, 010 subtract, 011 subtract with borrow, 100 AND, 101 XOR, 110 OR, 111 compare. This applies when the unary select is 00 or 11.
- R2: The sign flag is result bit 7. The zero flag is 1 exactly when the 8-bit result is 0x00.
- R3: Add and add with carry return (acc + operand + c) mod 256, where c is carry_in for 001 and 0 for 000. The half-carry flag is the carry out of bit 3 and the carry flag is the carry out of bit 7.
- R4: Subtract, subtract with borrow and compare form acc - operand - c, where c is carry_in for 011 and 0 otherwise. The half-carry flag is a borrow into bit 4 and the carry flag is a borrow out of bit 7.
- R5: For the add, subtract and compare operations, the parity/overflow flag is 1 when the signed two's-complement result falls outside -128..127.
- R6: AND sets half-carry to 1 and carry to 0. XOR and OR set both half-carry and carry to 0.
- R7: For AND, XOR and OR, the parity/overflow flag is 1 when the result holds an even number of 1 bits.
- R8: Compare drives the write-back enable low. Every other operation drives it high.
- R9: Unary select 01 returns operand + 1 and unary select 10 returns operand - 1, both mod 256. In these modes acc and the operation code have no effect and write-back is high. Half-carry is the carry out of bit 3 for increment and the borrow into bit 4 for decrement.
- R10: Increment sets parity/overflow only when the operand is 0x7F, and decrement sets it only when the operand is 0x80. In both unary modes the carry flag equals carry_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 3 | Binary operation code (R1 encoding) |
| unary_sel | input | 2 | 00/11 binary, 01 increment, 10 decrement |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Second operand, or the value to step in unary mode |
| carry_in | input | 1 | Current carry flag |
| result_o | output | 8 | Computed byte |
| flag_s_o | output | 1 | Sign |
| flag_z_o | output | 1 | Zero |
| flag_h_o | output | 1 | Half-carry / half-borrow |
| flag_pv_o | output | 1 | Parity or overflow |
| flag_c_o | output | 1 | Carry / borrow |
| wr_en_o | output | 1 | Result should be written back |

## Verification
The block holds no state, so a fault shows up only as a wrong flag or result byte for the same inputs. It is visible in the evaluation where it occurs and never later. Most faults act only on narrow input classes: a swapped borrow sense in the low nibble, a carry_in dropped on one opcode, or an overflow tap on the wrong bit. The sweeps therefore cover every accumulator value against a spread of operands that includes the nibble and sign boundaries. They run with both carry_in values for every opcode and unary mode.

// File: rtl/alu8_pkg.sv
// Shared encodings for the accumulator ALU.
// Assumes the decoder presents these codes unchanged from the opcode byte.
package alu8_pkg;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        OP_ADD = 3'b000,
        OP_ADC = 3'b001,
        OP_SUB = 3'b010,
        OP_SBC = 3'b011,
        OP_AND = 3'b100,
        OP_XOR = 3'b101,
        OP_OR  = 3'b110,
        OP_CMP = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        UN_NONE = 2'b00,
        UN_INC  = 2'b01,
        UN_DEC  = 2'b10,
        UN_RSV  = 2'b11
    } unary_e;
endpackage

// File: rtl/alu8_addsub.sv
// Shared adder/subtractor for all arithmetic paths.
// Subtraction is a + ~b + ~cin; carry and half outputs are returned as
// borrows when sub is high. Assumes W is even so the half point is W/2.
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o,
    output logic         half_o,
    output logic         ovf_o
);
    localparam int HALF = W / 2;

    logic [W-1:0] b_x;
    logic         c_x;
    logic [W:0]   full;

    // Condition the second operand and carry for add or subtract.
    always_comb begin
        b_x = sub_i ? ~b_i : b_i;
        c_x = sub_i ^ cin_i;
    end

    // Single wide sum; carry into the half point is recovered from sum bits.
    always_comb begin
        full    = {1'b0, a_i} + {1'b0, b_x} + {{W{1'b0}}, c_x};
        sum_o   = full[W-1:0];
        carry_o = full[W] ^ sub_i;
        half_o  = a_i[HALF] ^ b_x[HALF] ^ full[HALF] ^ sub_i;
        ovf_o   = (a_i[W-1] == b_x[W-1]) && (full[W-1] != a_i[W-1]);
    end
endmodule

// File: rtl/alu8_logic.sv
// Bitwise unit: AND, XOR, OR selected by the low two bits of the opcode.
// Assumes the caller only uses the output for the logic opcodes.
module alu8_logic #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [1:0]   fn_i,
    output logic [W-1:0] res_o,
    output logic         even_o
);
    logic [W-1:0] and_v, xor_v, or_v;

    // Per-bit gate columns.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign and_v[i] = a_i[i] & b_i[i];
        assign xor_v[i] = a_i[i] ^ b_i[i];
        assign or_v[i]  = a_i[i] | b_i[i];
    end

    // Select the function and compute even parity of the result.
    always_comb begin
        unique case (fn_i)
            2'b00:   res_o = and_v;
            2'b01:   res_o = xor_v;
            default: res_o = or_v;
        endcase
        even_o = ~^res_o;
    end
endmodule

// File: rtl/alu8_flagmux.sv
// Picks the result byte and the per-class flag rules.
// Assumes exactly one of is_unary_i / is_logic_i / arithmetic is active.
module alu8_flagmux #(
    parameter int W = 8
) (
    input  logic         is_unary_i,
    input  logic         is_logic_i,
    input  logic         is_and_i,
    input  logic         carry_in_i,
    input  logic [W-1:0] arith_i,
    input  logic         arith_c_i,
    input  logic         arith_h_i,
    input  logic         arith_v_i,
    input  logic [W-1:0] logic_i,
    input  logic         logic_even_i,
    output logic [W-1:0] result_o,
    output logic         s_o,
    output logic         z_o,
    output logic         h_o,
    output logic         pv_o,
    output logic         c_o
);
    // Merge result and flags by operation class.
    always_comb begin
        result_o = is_logic_i ? logic_i : arith_i;
        s_o      = result_o[W-1];
        z_o      = (result_o == '0);
        if (is_logic_i) begin
            h_o  = is_and_i;
            pv_o = logic_even_i;
            c_o  = 1'b0;
        end else begin
            h_o  = arith_h_i;
            pv_o = arith_v_i;
            c_o  = is_unary_i ? carry_in_i : arith_c_i;
        end
    end
endmodule

// File: rtl/alu8_core.sv
// Accumulator ALU top: routes operands to the shared adder or the bitwise
// unit, applies flag rules, and gates write-back on compare.
// Purely combinational; assumes the caller registers outputs.
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [2:0]   op_sel,
    input  logic [1:0]   unary_sel,
    input  logic [W-1:0] acc_in,
    input  logic [W-1:0] opnd_in,
    input  logic         carry_in,
    output logic [W-1:0] result_o,
    output logic         flag_s_o,
    output logic         flag_z_o,
    output logic         flag_h_o,
    output logic         flag_pv_o,
    output logic         flag_c_o,
    output logic         wr_en_o
);
    localparam logic [W-1:0] INC_EDGE = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] DEC_EDGE = {1'b1, {(W-1){1'b0}}};

    alu_op_e      op;
    unary_e       un;
    logic         is_un, is_dec, is_logic, is_cmp;
    logic [W-1:0] as_a, as_b;
    logic         as_cin, as_sub;
    logic [W-1:0] sum_w, lres_w;
    logic         sum_c, sum_h, sum_v, l_even;

    // Decode operation class.
    always_comb begin
        op       = alu_op_e'(op_sel);
        un       = unary_e'(unary_sel);
        is_un    = (un == UN_INC) || (un == UN_DEC);
        is_dec   = (un == UN_DEC);
        is_cmp   = !is_un && (op == OP_CMP);
        is_logic = !is_un && op_sel[2] && (op != OP_CMP);
    end

    // Route operands into the shared adder.
    always_comb begin
        if (is_un) begin
            as_a   = opnd_in;
            as_b   = '0;
            as_sub = is_dec;
            as_cin = 1'b1;
        end else begin
            as_a   = acc_in;
            as_b   = opnd_in;
            as_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
            as_cin = ((op == OP_ADC) || (op == OP_SBC)) ? carry_in : 1'b0;
        end
    end

    alu8_addsub #(.W(W)) addsub_i (
        .a_i(as_a), .b_i(as_b), .cin_i(as_cin), .sub_i(as_sub),
        .sum_o(sum_w), .carry_o(sum_c), .half_o(sum_h), .ovf_o(sum_v)
    );

    alu8_logic #(.W(W)) logic_i (
        .a_i(acc_in), .b_i(opnd_in), .fn_i(op_sel[1:0]),
        .res_o(lres_w), .even_o(l_even)
    );

    alu8_flagmux #(.W(W)) flagmux_i (
        .is_unary_i(is_un), .is_logic_i(is_logic), .is_and_i(op == OP_AND),
        .carry_in_i(carry_in),
        .arith_i(sum_w), .arith_c_i(sum_c), .arith_h_i(sum_h), .arith_v_i(sum_v),
        .logic_i(lres_w), .logic_even_i(l_even),
        .result_o(result_o), .s_o(flag_s_o), .z_o(flag_z_o), .h_o(flag_h_o),
        .pv_o(flag_pv_o), .c_o(flag_c_o)
    );

    // Write-back is suppressed only for compare.
    always_comb wr_en_o = !is_cmp;

    // Port-level guards on the flag rules.
    always_comb begin
        if (!is_un && op == OP_CMP)
            a_r8_cmp_no_write: assert (!wr_en_o);
        if (is_un)
            a_r10_unary_keeps_carry: assert (flag_c_o == carry_in);
        if (!is_un && op == OP_AND)
            a_r6_and_flags: assert (flag_h_o && !flag_c_o);
        if (!is_un && (op == OP_OR || op == OP_XOR))
            a_r6_orxor_flags: assert (!flag_h_o && !flag_c_o);
        if (un == UN_INC && flag_pv_o)
            a_r10_inc_edge: assert (opnd_in == INC_EDGE);
        if (un == UN_DEC && flag_pv_o)
            a_r10_dec_edge: assert (opnd_in == DEC_EDGE);
    end
endmodule

// File: tb/alu8_core_tb_top.sv
// Sweep bench: every accumulator value against a spread of operands, all
// opcodes, both carry values, plus full unary sweeps. Reference is integer math.
module alu8_core_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_sel = 3'b000;
    logic [1:0] unary_sel = 2'b00;
    logic [7:0] acc_in = 8'h00;
    logic [7:0] opnd_in = 8'h00;
    logic       carry_in = 1'b0;
    logic [7:0] result_o;
    logic       flag_s_o, flag_z_o, flag_h_o, flag_pv_o, flag_c_o, wr_en_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    alu8_core dut_i (
        .op_sel(op_sel), .unary_sel(unary_sel), .acc_in(acc_in),
        .opnd_in(opnd_in), .carry_in(carry_in), .result_o(result_o),
        .flag_s_o(flag_s_o), .flag_z_o(flag_z_o), .flag_h_o(flag_h_o),
        .flag_pv_o(flag_pv_o), .flag_c_o(flag_c_o), .wr_en_o(wr_en_o)
    );

    // Watchdog on the bench clock.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000 && !done) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic cmp(string req, int act, int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s op=%0d un=%0d a=%02h b=%02h ci=%0d: actual %0h expected %0h",
                     req, op_sel, unary_sel, acc_in, opnd_in, carry_in, act, exp);
        end
    endtask

    // Apply one vector, wait, compare against the integer reference.
    task automatic run_vec(int op, int un, int a, int b, int ci);
        int r, h, v, c, w, sa, sb, d, n;
        op_sel = op[2:0]; unary_sel = un[1:0];
        acc_in = a[7:0]; opnd_in = b[7:0]; carry_in = ci[0];
        #1;
        w = 1; c = ci;
        sa = (a > 127) ? a - 256 : a;
        sb = (b > 127) ? b - 256 : b;
        if (un == 1) begin
            r = (b + 1) % 256; h = ((b % 16) == 15); v = (b == 127);
        end else if (un == 2) begin
            r = (b + 255) % 256; h = ((b % 16) == 0); v = (b == 128);
        end else if (op <= 1) begin
            n = (op == 1) ? ci : 0;
            r = (a + b + n) % 256; c = (a + b + n) > 255;
            h = ((a % 16) + (b % 16) + n) > 15;
            d = sa + sb + n; v = (d > 127) || (d < -128);
        end else if (op == 2 || op == 3 || op == 7) begin
            n = (op == 3) ? ci : 0;
            d = a - b - n; c = d < 0; r = (d + 256) % 256;
            h = ((a % 16) - (b % 16) - n) < 0;
            d = sa - sb - n; v = (d > 127) || (d < -128);
            if (op == 7) w = 0;
        end else begin
            r = (op == 4) ? (a & b) : (op == 5) ? (a ^ b) : (a | b);
            h = (op == 4); c = 0;
            v = (($countones(r[7:0]) % 2) == 0);
        end
        if (un == 0 || un == 3) begin
            if (op <= 1)      cmp("R3 result", result_o, r);
            else if (op >= 4 && op <= 6) cmp("R1 result", result_o, r);
            else              cmp("R4 result", result_o, r);
        end else              cmp("R9 result", result_o, r);
        cmp("R2 sign", flag_s_o, r / 128);
        cmp("R2 zero", flag_z_o, (r == 0));
        cmp((un == 1 || un == 2) ? "R9 half" : (op >= 4 && op <= 6) ? "R6 half" : "R3/R4 half", flag_h_o, h);
        cmp((un == 1 || un == 2) ? "R10 pv" : (op >= 4 && op <= 6) ? "R7 pv" : "R5 pv", flag_pv_o, v);
        cmp((un == 1 || un == 2) ? "R10 carry" : (op >= 4 && op <= 6) ? "R6 carry" : "R3/R4 carry", flag_c_o, c);
        cmp("R8 wr_en", wr_en_o, w);
        #1;
    endtask

    initial begin
        int bl[24];
        bl = '{8'h00, 8'h01, 8'h0F, 8'h10, 8'h7F, 8'h80, 8'h81, 8'hFF,
               8'h08, 8'h55, 8'hAA, 8'hF0, 8'h3C, 8'h7E, 8'hFE, 8'h11,
               8'h22, 8'h44, 8'h99, 8'hC3, 8'h0E, 8'h1F, 8'h6F, 8'hE1};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Initial idle vector: add of zeros gives zero result, zero flag.
        run_vec(0, 0, 0, 0, 0);
        // R1 R3 R4 R5 R6 R7 R8: binary opcodes, both carry values.
        for (int op = 0; op < 8; op++)
            for (int ci = 0; ci < 2; ci++)
                for (int a = 0; a < 256; a++)
                    for (int k = 0; k < 24; k++)
                        run_vec(op, (a % 7 == 0) ? 3 : 0, a, bl[k], ci);
        // R9 R10: unary sweeps; acc and opcode varied to show they are ignored.
        for (int un = 1; un < 3; un++)
            for (int ci = 0; ci < 2; ci++)
                for (int b = 0; b < 256; b++)
                    run_vec(b % 8, un, (b * 37) % 256, b, ci);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule